// File: doc/BRIEF.md
# Linear Sensor Readout Controller

This block sits on the host side of a 256-pixel linear photodiode array. From the system clock it derives the sensor clock. It issues the start pulse that opens each readout frame, and it tells a downstream converter when each pixel's analog level is valid. For each pixel it gives a one-cycle sample strobe and a pixel index. Conversion and storage of the samples happen elsewhere. This block only produces the timing and the tags.

Every frame has 257 sensor clock pulses. Rising edges 1 to 256 present pixels 0 to 255, and edge 257 ends the array's serial-out pulse. The controller then waits out a programmable charge-transfer delay before another start pulse may go out. In continuous mode it also waits until a programmable integration period has run. That period is counted from rising edge 19, because the integrators leave their reset window on that edge. The next frame starts at whichever of the two limits is later. A single-shot request runs one frame and then returns to idle. The integration period and delay are captured when the start pulse is issued.

Top module: `lsa_readout_ctrl`

## Requirements
- R1: During and after reset, with no request, `si_o`, `sclk_o`, `strobe_o`, `done_o` and `busy_o` are low and `pix_idx_o` is 0.
- R2: Within a frame the sensor clock has a period of `DIV` system cycles and stays high for `DIV/2` of them. Outside a frame (`busy_o` low) it stays low.
- R3: `si_o` changes only while `sclk_o` is low. It is high on exactly one rising edge of `sclk_o` per frame, and that edge is edge 1.
- R4: Each frame has exactly 257 rising edges of `sclk_o`, with edge 1 being the one that samples `si_o` high.
- R5: Each frame has exactly 256 `strobe_o` pulses. Pulse k comes `SMP` system cycles after rising edge k+1 and carries `pix_idx_o` = k, for k = 0..255 in ascending order.
- R6: `done_o` is high for exactly one system cycle per frame: the cycle in which `sclk_o` falls after rising edge 257.
- R7: The next `si_o` rise comes at least `xfer_i`+2 system cycles after the `done_o` cycle.
- R8: `busy_o` rises together with `si_o` and falls exactly `xfer_i`+1 cycles after the `done_o` cycle.
- R9: In continuous mode, let L be the later of (edge-19 cycle + `integ_i`) and (`done_o` cycle + `xfer_i`). The next `si_o` rise falls in the window from L+2 to L+`DIV`+1 system cycles.
- R10: A `start_i` pulse while idle runs exactly one frame and the block then returns to idle. A `start_i` pulse while `busy_o` is high has no effect.
- R11: `integ_i` and `xfer_i` are captured when `si_o` rises. A change to them during a frame does not alter that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-frame request pulse, accepted only when idle |
| cont_i | input | 1 | Continuous-mode level; frames repeat while high |
| integ_i | input | IW | Integration period in system cycles, counted from edge 19 |
| xfer_i | input | TW | Charge-transfer delay in system cycles after the frame ends |
| si_o | output | 1 | Start pulse to the sensor |
| sclk_o | output | 1 | Sensor clock |
| strobe_o | output | 1 | Per-pixel sample strobe for the converter |
| pix_idx_o | output | PXW | Index of the pixel being sampled, valid with `strobe_o` |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| busy_o | output | 1 | High from the start pulse until the transfer delay ends |

## Verification
The hardest situation to reach from the ports is the continuous-mode start decision. Here the integration limit, counted from edge 19 of the previous frame, has to be weighed against the transfer delay counted from that frame's end. Reaching each side requires holding `cont_i` across two whole frames, with period and delay values chosen so that one limit clearly outlasts the other. The stimulus runs two such pairs, one where the delay dominates and one where integration dominates. Each time, the bench records the edge-19 and end-of-frame cycles of the first frame and checks the second start pulse against the window. A separate single-shot run changes `xfer_i` and pulses `start_i` mid-frame to show that neither has any effect.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_RUN,
        S_XFER,
        S_WINT
    } lsa_state_e;
endpackage

// File: rtl/lsa_phase.sv
// Free-running phase counter that marks the system cycle before each
// sensor-clock rising edge, falling edge and sample point.
module lsa_phase #(
    parameter int DIV = 4,
    parameter int SMP = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic rise_nx,
    output logic fall_nx,
    output logic smp_nx
);
    localparam int PW       = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF     = DIV / 2;
    localparam int SMP_PREV = (SMP + DIV - 1) % DIV;

    typedef struct packed {
        logic [PW-1:0] ph;
    } ph_t;

    ph_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.ph == PW'(DIV - 1)) r_d.ph = '0;
        else                        r_d.ph = r_q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rise_nx = (r_q.ph == PW'(DIV - 1));
    assign fall_nx = (r_q.ph == PW'(HALF - 1));
    assign smp_nx  = (r_q.ph == PW'(SMP_PREV));
endmodule

// File: rtl/lsa_timer.sv
// Saturating up-counter: cleared on demand, reports when limit reached.
module lsa_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         expired
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tm_t;

    tm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr)                  r_d.cnt = '0;
        else if (r_q.cnt < limit) r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign expired = (r_q.cnt >= limit);
endmodule

// File: rtl/lsa_readout_ctrl.sv
module lsa_readout_ctrl #(
    parameter int DIV      = 4,
    parameter int SMP      = 1,
    parameter int NPIX     = 256,
    parameter int RST_CLKS = 18,
    parameter int IW       = 20,
    parameter int TW       = 16,
    parameter int PXW      = $clog2(NPIX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           cont_i,
    input  logic [IW-1:0]  integ_i,
    input  logic [TW-1:0]  xfer_i,
    output logic           si_o,
    output logic           sclk_o,
    output logic           strobe_o,
    output logic [PXW-1:0] pix_idx_o,
    output logic           done_o,
    output logic           busy_o
);
    import lsa_pkg::*;

    localparam int NCLK = NPIX + 1;
    localparam int CW   = $clog2(NCLK + 1);

    typedef struct packed {
        lsa_state_e     st;
        logic           si;
        logic           sclk;
        logic [CW-1:0]  ck;
        logic           strobe;
        logic [PXW-1:0] idx;
        logic           done;
        logic           busy;
        logic [IW-1:0]  integ;
        logic [TW-1:0]  xfer;
    } ctl_t;

    ctl_t r_d, r_q;

    logic          rise_nx, fall_nx, smp_nx;
    logic          int_clr, xf_clr;
    logic          int_exp, xf_exp;
    logic [CW-1:0] ck_nx;

    lsa_phase #(.DIV(DIV), .SMP(SMP)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_nx (rise_nx),
        .fall_nx (fall_nx),
        .smp_nx  (smp_nx)
    );

    // integration window: starts on the edge that ends the reset window
    lsa_timer #(.W(IW)) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (int_clr),
        .limit   (r_q.integ),
        .expired (int_exp)
    );

    // charge-transfer delay after the final edge
    lsa_timer #(.W(TW)) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (xf_clr),
        .limit   (r_q.xfer),
        .expired (xf_exp)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.strobe = 1'b0;
        int_clr    = 1'b0;
        xf_clr     = 1'b0;
        ck_nx      = r_q.ck;
        unique case (r_q.st)
            S_IDLE: begin
                if (start_i || cont_i) r_d.st = S_ARM;
            end
            S_ARM: begin
                // raise the start pulse only as the sensor clock goes low
                if (fall_nx) begin
                    r_d.st    = S_RUN;
                    r_d.si    = 1'b1;
                    r_d.busy  = 1'b1;
                    r_d.ck    = '0;
                    r_d.integ = integ_i;
                    r_d.xfer  = xfer_i;
                end
            end
            S_RUN: begin
                if (rise_nx) begin
                    ck_nx    = r_q.ck + 1'b1;
                    r_d.sclk = 1'b1;
                    if (r_q.ck == CW'(RST_CLKS)) int_clr = 1'b1;
                end
                if (fall_nx) begin
                    r_d.sclk = 1'b0;
                    r_d.si   = 1'b0;
                    if (r_q.ck == CW'(NCLK)) begin
                        r_d.st   = S_XFER;
                        r_d.done = 1'b1;
                        xf_clr   = 1'b1;
                    end
                end
                r_d.ck = ck_nx;
                if (smp_nx && (ck_nx != '0) && (ck_nx <= CW'(NPIX))) begin
                    r_d.strobe = 1'b1;
                    r_d.idx    = PXW'(ck_nx - 1'b1);
                end
            end
            S_XFER: begin
                if (xf_exp) begin
                    r_d.busy = 1'b0;
                    if (!cont_i)      r_d.st = S_IDLE;
                    else if (int_exp) r_d.st = S_ARM;
                    else              r_d.st = S_WINT;
                end
            end
            S_WINT: begin
                if (!cont_i)      r_d.st = S_IDLE;
                else if (int_exp) r_d.st = S_ARM;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign si_o      = r_q.si;
    assign sclk_o    = r_q.sclk;
    assign strobe_o  = r_q.strobe;
    assign pix_idx_o = r_q.idx;
    assign done_o    = r_q.done;
    assign busy_o    = r_q.busy;
endmodule

// File: rtl/lsa_readout_ctrl_chk.sv
module lsa_readout_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic si_o,
    input logic sclk_o,
    input logic strobe_o,
    input logic done_o,
    input logic busy_o
);
    p_si_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(si_o) |-> !sclk_o);

    p_si_one_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> !si_o);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!sclk_o && busy_o));

    p_busy_with_si_r8: assert property (@(posedge clk) disable iff (!rst_n)
        si_o |-> busy_o);

    p_strobe_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> busy_o);

    p_idle_clk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

    p_si_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si_o) |-> !$past(busy_o));
endmodule

bind lsa_readout_ctrl lsa_readout_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .si_o     (si_o),
    .sclk_o   (sclk_o),
    .strobe_o (strobe_o),
    .done_o   (done_o),
    .busy_o   (busy_o)
);

// File: tb/lsa_readout_ctrl_test.sv
`timescale 1ns/1ps
module lsa_readout_ctrl_test;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int SMP  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cont_i = 1'b0;
    logic [19:0] integ_i = '0;
    logic [15:0] xfer_i = '0;
    logic        si_o, sclk_o, strobe_o, done_o, busy_o;
    logic [7:0]  pix_idx_o;

    always #10 clk = ~clk;

    lsa_readout_ctrl #(.DIV(DIV), .SMP(SMP)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cont_i    (cont_i),
        .integ_i   (integ_i),
        .xfer_i    (xfer_i),
        .si_o      (si_o),
        .sclk_o    (sclk_o),
        .strobe_o  (strobe_o),
        .pix_idx_o (pix_idx_o),
        .done_o    (done_o),
        .busy_o    (busy_o)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int edges = 0, si_edges = 0, frame_edges = 0;
    int rise_cyc = 0, t19 = 0, t_si = 0, t_done = 0, t_bfall = 0;
    int prev_t19 = 0, prev_done = 0;
    int nsi = 0, ndone = 0, nbf = 0, nstb = 0, exp_idx = 0;
    int si_bad = 0, hi_bad = 0, per_bad = 0, stb_bad = 0, done_bad = 0, idle_bad = 0;
    logic p_sclk = 1'b0, p_si = 1'b0, p_done = 1'b0, p_busy = 1'b0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // port monitor, sampled on the falling system clock edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (si_o != p_si && sclk_o) si_bad++;
            if (si_o && !p_si) begin
                if (sclk_o) si_bad++;
                prev_t19 = t19; prev_done = t_done; t_si = cyc; nsi++;
                edges = 0; si_edges = 0; exp_idx = 0; nstb = 0;
            end
            if (sclk_o && !p_sclk) begin
                if (edges > 0 && cyc - rise_cyc != DIV) per_bad++;
                edges++; rise_cyc = cyc;
                if (edges == 19) t19 = cyc;
                if (si_o) si_edges++;
            end
            if (!sclk_o && p_sclk && cyc - rise_cyc != HALF) hi_bad++;
            if (strobe_o) begin
                if (cyc - rise_cyc != SMP || int'(pix_idx_o) != exp_idx) stb_bad++;
                exp_idx++; nstb++;
            end
            if (done_o) begin
                if (p_done) done_bad++;
                t_done = cyc; frame_edges = edges; ndone++;
            end
            if (!busy_o && p_busy) begin t_bfall = cyc; nbf++; end
            if (sclk_o && !busy_o) idle_bad++;
        end
        p_sclk = sclk_o; p_si = si_o; p_done = done_o; p_busy = busy_o;
    end

    always @(negedge clk) begin
        if (cyc > 100000 && !finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            summary();
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame_checks(input int n0);
        chk(si_edges == 1 && si_bad == 0, "R3 si sampled once, low clock", si_edges, 1);
        chk(frame_edges == 257, "R4 edges per frame", frame_edges, 257);
        chk(nstb == 256 && stb_bad == 0, "R5 strobe count/index/offset", nstb + 1000 * stb_bad, 256);
        chk(hi_bad == 0 && per_bad == 0, "R2 clock shape", hi_bad + per_bad, 0);
        chk(done_bad == 0 && ndone == n0, "R6 done pulse", ndone, n0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        chk({si_o, sclk_o, strobe_o, done_o, busy_o} == 5'b0 && pix_idx_o == 0,
            "R1 outputs in reset", {si_o, sclk_o, strobe_o, done_o, busy_o}, 0);
        rst_n = 1'b1;
        wait_cyc(20);
        chk({si_o, sclk_o, strobe_o, done_o, busy_o} == 5'b0 && pix_idx_o == 0,
            "R1 outputs idle after reset", {si_o, sclk_o, strobe_o, done_o, busy_o}, 0);
        chk(nsi == 0 && idle_bad == 0, "R2 no clock while idle", nsi + idle_bad, 0);
    endtask

    task automatic t_single(input int integ, input int xfer, input bit disturb);
        int s0, d0, b0;
        s0 = nsi; d0 = ndone; b0 = nbf;
        integ_i = 20'(integ); xfer_i = 16'(xfer);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        while (nsi == s0) @(negedge clk);
        if (disturb) begin
            wait_cyc(300);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
            xfer_i = 16'(xfer + 500);
        end
        while (nbf == b0) @(negedge clk);
        wait_cyc(60);
        frame_checks(d0 + 1);
        chk(t_bfall - t_done == xfer + 1, disturb ? "R11 captured delay" : "R8 busy fall",
            t_bfall - t_done, xfer + 1);
        chk(nsi == s0 + 1, "R10 one frame per start", nsi - s0, 1);
        chk(idle_bad == 0 && !busy_o, "R2 clock low after frame", idle_bad, 0);
    endtask

    task automatic t_cont(input int integ, input int xfer, input bit integ_dom);
        int s0, b0, lo, a, b;
        s0 = nsi; b0 = nbf;
        integ_i = 20'(integ); xfer_i = 16'(xfer);
        cont_i = 1'b1;
        while (nsi < s0 + 2) @(negedge clk);
        cont_i = 1'b0;
        a = prev_t19 + integ; b = prev_done + xfer;
        chk((a > b) == integ_dom, "R9 scenario limit choice", a - b, 0);
        lo = ((a > b) ? a : b) + 2;
        chk(t_si >= lo && t_si <= lo + DIV - 1,
            integ_dom ? "R9 start after integration" : "R9 start after transfer",
            t_si, lo);
        chk(t_si - prev_done >= xfer + 2, "R7 transfer gap", t_si - prev_done, xfer + 2);
        while (nbf < b0 + 2) @(negedge clk);
        wait_cyc(DIV * 30);
        chk(nsi == s0 + 2 && !busy_o, "R10 stops when mode drops", nsi - s0, 2);
        frame_checks(ndone);
    endtask

    initial begin
        t_reset();
        t_single(0, 50, 1'b0);
        t_single(0, 0, 1'b0);
        t_single(0, 40, 1'b1);
        t_cont(100, 300, 1'b0);
        t_cont(2500, 20, 1'b1);
        summary();
    end
endmodule